// File: doc/BRIEF.md
# Count/Compare Interval Timer

A free-running counter register advances by one on every cycle in which a timebase enable is high. Its value is compared continuously with a compare register. When the two are equal, a sticky timer interrupt is raised on one of eight output lines. A 3-bit line-select input chooses the line. Writing the compare register acknowledges the interrupt. Software sets the compare register to the count value at which the next interrupt should occur.

A freeze input stops the counter at its current value and suppresses match events. Counting resumes from the held value when freeze is released. A pending status bit mirrors the interrupt only when the 3-bit revision input equals 1. For every other revision code the bit keeps its value, while the output line behaves as usual.

Top module: `cmp_timer`

## Requirements
- R1: After reset, count is 1, compare is 0, every interrupt line is low and the pending bit is 0.
- R2: On each clock edge with tick high and freeze low, count increases by one, wrapping from 0xFFFFFFFF to 0.
- R3: A count write loads the written value on that edge, even when a tick would otherwise increment it.
- R4: While freeze is high, count holds its value and the count output shows that held value. After freeze is released, count continues from the held value with one increment per tick.
- R5: While freeze is high, a count equal to compare raises no interrupt.
- R6: A clock edge at which count equals compare, freeze is low and no compare write occurs sets the interrupt. Interrupt line `line_sel` (bit index of `irq_o`) is then high from that edge on, and stays high while count moves on, until a compare write or reset.
- R7: A compare write loads compare and clears the interrupt and the pending bit on that edge. The write takes priority over a match at the same edge.
- R8: The pending bit is set by a match and cleared by a compare write only when `rev_code` is 3'b001. For any other code the bit is unchanged, while the interrupt line is still driven.
- R9: At most one interrupt line is high at a time. Changing `line_sel` moves an active interrupt to the new line at once.
- R10: The compare output shows the last value written to compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase enable |
| freeze | input | 1 | Count disable; also masks matches |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write value |
| cmp_we | input | 1 | Compare write strobe; acknowledges the interrupt |
| cmp_wdata | input | 32 | Compare write value |
| rev_code | input | 3 | Revision code; pending bit tracked only for 1 |
| line_sel | input | 3 | Selects the interrupt output line |
| count_o | output | 32 | Current count |
| compare_o | output | 32 | Current compare |
| tmr_pending | output | 1 | Timer pending status bit |
| irq_o | output | 8 | Interrupt output vector |

## Verification
The assertions assume that reset is held low for at least one edge, that all inputs are known whenever reset is high, and that `rev_code` and `line_sel` are static values chosen by software rather than signals toggled every cycle. The stimulus changes inputs only on the falling clock edge and holds `line_sel` steady around each check, except where the move of an active interrupt to another line is itself under test. Matches are set up by writing compare with the current count while ticks are stopped, so that each match edge is known exactly.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int CW     = 32,
  parameter int NLINES = 8,
  parameter int REVW   = 3,
  parameter logic [REVW-1:0] TRACK_REV = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      freeze,
  input  logic                      cnt_we,
  input  logic [CW-1:0]             cnt_wdata,
  input  logic                      cmp_we,
  input  logic [CW-1:0]             cmp_wdata,
  input  logic [REVW-1:0]           rev_code,
  input  logic [$clog2(NLINES)-1:0] line_sel,
  output logic [CW-1:0]             count_o,
  output logic [CW-1:0]             compare_o,
  output logic                      tmr_pending,
  output logic [NLINES-1:0]         irq_o
);
  localparam int SELW = $clog2(NLINES);

  logic [CW-1:0] count_q, compare_q;
  logic          irq_q, pend_q;
  logic          hit, track;

  assign hit   = !freeze && (count_q == compare_q);
  assign track = (rev_code == TRACK_REV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= CW'(1);
    end else if (cnt_we) begin
      count_q <= cnt_wdata;
    end else if (tick && !freeze) begin
      count_q <= count_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      compare_q <= '0;
      irq_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      if (cmp_we) compare_q <= cmp_wdata;
      if (cmp_we)   irq_q <= 1'b0;
      else if (hit) irq_q <= 1'b1;
      if (track) begin
        if (cmp_we)   pend_q <= 1'b0;
        else if (hit) pend_q <= 1'b1;
      end
    end
  end

  assign count_o     = count_q;
  assign compare_o   = compare_q;
  assign tmr_pending = pend_q;
  assign irq_o       = irq_q ? (NLINES'(1) << line_sel) : '0;

  // R2
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !freeze && !cnt_we) |=> (count_o == $past(count_o) + CW'(1)));
  // R3
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count_o == $past(cnt_wdata)));
  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_we) |=> $stable(count_o));
  // R5
  freeze_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && irq_o == '0) |=> (irq_o == '0));
  // R6
  match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && !cmp_we && count_o == compare_o) |=> (irq_o != '0));
  // R7
  cmp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (irq_o == '0));
  // R8
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_code != TRACK_REV) |=> $stable(tmr_pending));
  // R9
  one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));
  // R10
  cmp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (compare_o == $past(cmp_wdata)));

  logic unused_sel;
  assign unused_sel = ^{SELW'(0)};
endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  logic        clk = 0, rst_n = 0, tick = 0, freeze = 0;
  logic        cnt_we = 0, cmp_we = 0;
  logic [31:0] cnt_wdata = 0, cmp_wdata = 0;
  logic [2:0]  rev_code = 3'd1, line_sel = 0;
  logic [31:0] count_o, compare_o;
  logic        tmr_pending;
  logic [7:0]  irq_o;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  cmp_timer u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .rev_code(rev_code), .line_sel(line_sel), .count_o(count_o), .compare_o(compare_o),
    .tmr_pending(tmr_pending), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cmp(input logic [31:0] v);
    cmp_we = 1; cmp_wdata = v; cyc(1); cmp_we = 0;
  endtask

  task automatic wr_cnt(input logic [31:0] v);
    cnt_we = 1; cnt_wdata = v; cyc(1); cnt_we = 0;
  endtask

  initial begin
    #2_000_000;
    checks++; failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] c;
    cyc(3);
    // R1 reset state
    check("R1 count", count_o, 32'd1);
    check("R1 compare", compare_o, 32'd0);
    check("R1 irq", 32'(irq_o), 32'd0);
    check("R1 pend", 32'(tmr_pending), 32'd0);
    rst_n = 1;
    wr_cmp(32'h8000_0000);
    check("R10 compare", compare_o, 32'h8000_0000);
    // R2 sweep of tick run lengths
    for (int n = 0; n < 20; n++) begin
      wr_cnt(32'd100);
      tick = 1; cyc(n); tick = 0;
      check("R2 inc", count_o, 32'd100 + 32'(n));
    end
    wr_cnt(32'hFFFF_FFFE);
    tick = 1; cyc(3); tick = 0;
    check("R2 wrap", count_o, 32'd1);
    // R3 write beats tick
    tick = 1; wr_cnt(32'h1234_5678); tick = 0;
    check("R3 prio", count_o, 32'h1234_5678);
    // R4 freeze holds and resumes
    wr_cnt(32'd500);
    tick = 1; freeze = 1; cyc(7);
    check("R4 hold", count_o, 32'd500);
    freeze = 0; cyc(4); tick = 0;
    check("R4 resume", count_o, 32'd504);
    // R5 freeze masks match
    freeze = 1; wr_cmp(32'd504); cyc(4);
    check("R5 mask", 32'(irq_o), 32'd0);
    freeze = 0; cyc(1);
    check("R5 unmask", 32'(irq_o), 32'd1);
    wr_cmp(32'd9999);
    // R6 R7 R9 sweep over every line
    for (int s = 0; s < 8; s++) begin
      line_sel = 3'(s);
      c = count_o;
      wr_cmp(c); cyc(1);
      check("R6 line", 32'(irq_o), 32'd1 << s);
      check("R8 pend set", 32'(tmr_pending), 32'd1);
      tick = 1; cyc(3); tick = 0;
      check("R6 sticky", 32'(irq_o), 32'd1 << s);
      line_sel = 3'((s + 1) % 8); #1;
      check("R9 move", 32'(irq_o), 32'd1 << ((s + 1) % 8));
      cyc(1);
      wr_cmp(c + 32'd1000);
      check("R7 clear irq", 32'(irq_o), 32'd0);
      check("R7 clear pend", 32'(tmr_pending), 32'd0);
      check("R10 readback", compare_o, c + 32'd1000);
    end
    // R7 compare write wins over simultaneous match
    line_sel = 3'd2;
    c = count_o;
    wr_cmp(c); cyc(1);
    check("R7 setup", 32'(irq_o), 32'd4);
    wr_cmp(c);
    check("R7 prio", 32'(irq_o), 32'd0);
    cyc(1);
    check("R7 rematch", 32'(irq_o), 32'd4);
    wr_cmp(c + 32'd50);
    // R8 pending only for revision 1
    rev_code = 3'd0;
    wr_cmp(c); cyc(1);
    check("R8 irq rev0", 32'(irq_o), 32'd4);
    check("R8 no set", 32'(tmr_pending), 32'd0);
    rev_code = 3'd1; cyc(1);
    check("R8 set rev1", 32'(tmr_pending), 32'd1);
    rev_code = 3'd2;
    wr_cmp(c + 32'd50);
    check("R8 irq cleared", 32'(irq_o), 32'd0);
    check("R8 no clear", 32'(tmr_pending), 32'd1);
    rev_code = 3'd1;
    wr_cmp(c + 32'd60);
    check("R8 clear rev1", 32'(tmr_pending), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule